// File: doc/BRIEF.md
# Serial Port Register File (8250-compatible, no FIFO)

This block holds the programmer-visible registers of a serial port that has no receive or transmit FIFO. It also works out the interrupt identification for that port. A host reaches it through a 3-bit offset with separate read and write strobes. Read data is combinational while the read strobe is high, and every read or write side effect takes hold at the clock edge that ends the access. A byte written to the data offset leaves at once on a transmit strobe with its data. A line-side source delivers received bytes and break on/off events. The serial shifting itself, any buffering and the baud pacing all live elsewhere. The pacing block only tells this block, through `tx_hold`, when the transmit-ready interrupt must be withheld.

Several offsets have fixed or destructive behaviour. Line status always shows the transmitter idle and ready. Modem status reports fixed asserted handshake lines. Scratch writes always store 0xFF. Reading the interrupt identification consumes the transmit-ready cause, and reading the data register consumes the receive-ready cause. The interrupt request is high whenever the identification register's bit 0 (the "nothing pending" flag) is 0.

Top module: `uart_regs`

## Requirements
- R1: After reset the registers read as: data 0x00, interrupt enable 0x00, interrupt identification 0x01, line control 0x00, modem control 0x00, line status 0x60, modem status 0xB0, scratch 0x00, divisor low 0x01, divisor high 0x00; `irq` is low.
- R2: Offsets are 0 data, 1 interrupt enable, 2 identification (read) / FIFO control (write), 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch. While line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte; such accesses emit no transmit strobe and leave every other register unchanged.
- R3: A data write with line control bit 7 clear raises `tx_valid` in the same cycle with `tx_data` equal to the written byte. If interrupt enable bit 1 is set and `tx_hold` is low, identification bit 1 is set and bit 0 cleared.
- R4: A data read while line status bit 0 is set returns the held byte, then zeroes the data register and clears line status bit 0. Without bit 0 set, it returns the current (stale) data value and changes nothing in line status.
- R5: Every data read clears identification bit 2; if the identification value is then 0x00 it becomes 0x01. The identification register never holds 0x00.
- R6: An identification read returns the current value, after which bit 1 is cleared and a result of 0x00 becomes 0x01. Writes to offset 2 change no readable register.
- R7: Line status reads return the stored value with bits 6 and 5 forced to 1. Writes to offsets 5 and 6 are ignored.
- R8: Modem status reads always return 0xB0 (carrier detect bit 7, data set ready bit 5, clear to send bit 4).
- R9: A scratch write stores 0xFF whatever the written byte.
- R10: An interrupt-enable write whose bit 1 is set also sets identification bit 1 but leaves identification bit 0 unchanged.
- R11: A receive event (`rx_kind` 0 byte, 3 treated as byte) is taken only while line status bit 0 is clear, after that cycle's bus access. A taken event loads the data register and sets line status bit 0. If interrupt enable bit 0 is set, it also sets identification bit 2 and clears bit 0. An event arriving while bit 0 is set is dropped.
- R12: `rx_kind` 1 sets line status bit 4 and `rx_kind` 2 clears it. Both deliver a data byte of 0x00 under the same acceptance rule as R11.
- R13: `irq` is high exactly when identification bit 0 is 0.
- R14: Line control and modem control read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe (ignored when reg_wr is high) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high, else 0 |
| tx_hold | input | 1 | Pacing hold: suppresses the transmit-ready cause on a data write |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive event strobe |
| rx_kind | input | 2 | 0 byte, 1 break on, 2 break off, 3 byte |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |

## Verification
The block has one configuration that matters: the divisor reset of 0x0001 and the scratch fill of 0xFF, which are the defaults and the values the bench is built with. With 8-bit registers, every data byte can be swept through transmit, receive, scratch, modem control and both divisor halves. The bench also walks line control over all values with bit 7 clear. Directed sequences then combine the transmit and receive causes, breaks, dropped receive events and divisor-mode reads, so that every ordering of the identification side effects is reached.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam int RW = 8;
  typedef logic [RW-1:0] byte_t;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam int IIR_IDLE_B  = 0;
  localparam int IIR_TX_B    = 1;
  localparam int IIR_RX_B    = 2;
  localparam int LSR_RXRDY_B = 0;
  localparam int LSR_BRK_B   = 4;
  localparam int LSR_THRE_B  = 5;
  localparam int LSR_TEMT_B  = 6;
  localparam int IER_RX_B    = 0;
  localparam int IER_TX_B    = 1;
  localparam int LCR_DLAB_B  = 7;

  localparam byte_t MSR_FIXED = 8'hB0;
  localparam byte_t IIR_QUIET = 8'h01;

  typedef enum logic [1:0] {
    RX_BYTE    = 2'd0,
    RX_BRK_ON  = 2'd1,
    RX_BRK_OFF = 2'd2,
    RX_ALT     = 2'd3
  } rx_kind_e;

  typedef struct packed {
    logic wr_thr;
    logic rd_rbr;
    logic wr_dll;
    logic wr_dlm;
    logic wr_ier;
    logic rd_iir;
    logic wr_lcr;
    logic wr_mcr;
    logic wr_scr;
    logic rd_lsr;
  } acc_t;

  function automatic byte_t iir_settle(byte_t v);
    return (v == '0) ? IIR_QUIET : v;
  endfunction

  function automatic byte_t lsr_view(byte_t v);
    byte_t r;
    r = v;
    r[LSR_THRE_B] = 1'b1;
    r[LSR_TEMT_B] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
(
  input  logic [2:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic       dlab,
  output acc_t       acc
);

  logic rd_q;
  assign rd_q = rd & ~wr;

  always_comb begin
    acc        = '0;
    acc.wr_thr = wr   & (addr == OFS_DATA) & ~dlab;
    acc.wr_dll = wr   & (addr == OFS_DATA) &  dlab;
    acc.rd_rbr = rd_q & (addr == OFS_DATA) & ~dlab;
    acc.wr_ier = wr   & (addr == OFS_IER)  & ~dlab;
    acc.wr_dlm = wr   & (addr == OFS_IER)  &  dlab;
    acc.rd_iir = rd_q & (addr == OFS_IIR);
    acc.wr_lcr = wr   & (addr == OFS_LCR);
    acc.wr_mcr = wr   & (addr == OFS_MCR);
    acc.wr_scr = wr   & (addr == OFS_SCR);
    acc.rd_lsr = rd_q & (addr == OFS_LSR);
  end

endmodule

// File: rtl/uart_rf_rxsel.sv
module uart_rf_rxsel
  import uart_rf_pkg::*;
(
  input  rx_kind_e kind,
  input  byte_t    din,
  output byte_t    rx_byte,
  output logic     brk_on,
  output logic     brk_off
);

  always_comb begin
    brk_on  = 1'b0;
    brk_off = 1'b0;
    rx_byte = din;
    unique case (kind)
      RX_BRK_ON: begin
        brk_on  = 1'b1;
        rx_byte = '0;
      end
      RX_BRK_OFF: begin
        brk_off = 1'b1;
        rx_byte = '0;
      end
      default: rx_byte = din;
    endcase
  end

endmodule

// File: rtl/uart_rf_core.sv
module uart_rf_core
  import uart_rf_pkg::*;
#(
  parameter logic [15:0] DIV_RESET    = 16'h0001,
  parameter logic [7:0]  SCRATCH_FILL = 8'hFF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  acc_t     acc,
  input  byte_t    wdata,
  input  logic     tx_hold,
  input  logic     rx_valid,
  input  rx_kind_e rx_kind,
  input  byte_t    rx_data,
  output byte_t    data_q,
  output byte_t    dll_q,
  output byte_t    dlm_q,
  output byte_t    ier_q,
  output byte_t    iir_q,
  output byte_t    lcr_q,
  output byte_t    mcr_q,
  output byte_t    lsr_q,
  output byte_t    scr_q,
  output logic     rx_take
);

  localparam byte_t DLL_RST = DIV_RESET[7:0];
  localparam byte_t DLM_RST = DIV_RESET[15:8];

  byte_t n_data, n_dll, n_dlm, n_ier, n_iir, n_lcr, n_mcr, n_lsr, n_scr;
  byte_t rx_byte;
  logic  brk_on, brk_off;

  uart_rf_rxsel u_rxsel (
    .kind    (rx_kind),
    .din     (rx_data),
    .rx_byte (rx_byte),
    .brk_on  (brk_on),
    .brk_off (brk_off)
  );

  // Bus access is applied first, the receive event second, on the result.
  always_comb begin
    n_data = data_q;
    n_dll  = dll_q;
    n_dlm  = dlm_q;
    n_ier  = ier_q;
    n_iir  = iir_q;
    n_lcr  = lcr_q;
    n_mcr  = mcr_q;
    n_lsr  = lsr_q;
    n_scr  = scr_q;

    if (acc.wr_dll) n_dll = wdata;
    if (acc.wr_dlm) n_dlm = wdata;
    if (acc.wr_lcr) n_lcr = wdata;
    if (acc.wr_mcr) n_mcr = wdata;
    if (acc.wr_scr) n_scr = SCRATCH_FILL;

    if (acc.wr_ier) begin
      n_ier = wdata;
      if (wdata[IER_TX_B]) n_iir[IIR_TX_B] = 1'b1;
    end

    if (acc.wr_thr && ier_q[IER_TX_B] && !tx_hold) begin
      n_iir[IIR_TX_B]   = 1'b1;
      n_iir[IIR_IDLE_B] = 1'b0;
    end

    if (acc.rd_rbr) begin
      if (lsr_q[LSR_RXRDY_B]) begin
        n_data             = '0;
        n_lsr[LSR_RXRDY_B] = 1'b0;
      end
      n_iir[IIR_RX_B] = 1'b0;
      n_iir           = iir_settle(n_iir);
    end

    if (acc.rd_iir) begin
      n_iir[IIR_TX_B] = 1'b0;
      n_iir           = iir_settle(n_iir);
    end

    rx_take = rx_valid & ~n_lsr[LSR_RXRDY_B];
    if (rx_take) begin
      if (brk_on)  n_lsr[LSR_BRK_B] = 1'b1;
      if (brk_off) n_lsr[LSR_BRK_B] = 1'b0;
      n_data             = rx_byte;
      n_lsr[LSR_RXRDY_B] = 1'b1;
      if (n_ier[IER_RX_B]) begin
        n_iir[IIR_RX_B]   = 1'b1;
        n_iir[IIR_IDLE_B] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dll_q  <= DLL_RST;
      dlm_q  <= DLM_RST;
      ier_q  <= '0;
      iir_q  <= IIR_QUIET;
      lcr_q  <= '0;
      mcr_q  <= '0;
      lsr_q  <= '0;
      scr_q  <= '0;
    end else begin
      data_q <= n_data;
      dll_q  <= n_dll;
      dlm_q  <= n_dlm;
      ier_q  <= n_ier;
      iir_q  <= n_iir;
      lcr_q  <= n_lcr;
      mcr_q  <= n_mcr;
      lsr_q  <= n_lsr;
      scr_q  <= n_scr;
    end
  end

endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
  import uart_rf_pkg::*;
(
  input  logic [2:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic       dlab,
  input  byte_t      data_q,
  input  byte_t      dll_q,
  input  byte_t      dlm_q,
  input  byte_t      ier_q,
  input  byte_t      iir_q,
  input  byte_t      lcr_q,
  input  byte_t      mcr_q,
  input  byte_t      lsr_q,
  input  byte_t      scr_q,
  output byte_t      rdata
);

  byte_t sel;

  always_comb begin
    unique case (addr)
      OFS_DATA: sel = dlab ? dll_q : data_q;
      OFS_IER:  sel = dlab ? dlm_q : ier_q;
      OFS_IIR:  sel = iir_q;
      OFS_LCR:  sel = lcr_q;
      OFS_MCR:  sel = mcr_q;
      OFS_LSR:  sel = lsr_view(lsr_q);
      OFS_MSR:  sel = MSR_FIXED;
      default:  sel = scr_q;
    endcase
  end

  assign rdata = (rd && !wr) ? sel : '0;

endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_rf_pkg::*;
#(
  parameter logic [15:0] DIV_RESET    = 16'h0001,
  parameter logic [7:0]  SCRATCH_FILL = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tx_hold,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       rx_valid,
  input  logic [1:0] rx_kind,
  input  logic [7:0] rx_data,
  output logic       irq
);

  acc_t  acc;
  byte_t data_q, dll_q, dlm_q, ier_q, iir_q, lcr_q, mcr_q, lsr_q, scr_q;
  logic  rx_take;

  // Named events for the checker
  logic dlab, rd_iir_ev, rd_data_ev, wr_scr_ev, lsr_rd_ev;
  assign dlab       = lcr_q[LCR_DLAB_B];
  assign rd_iir_ev  = acc.rd_iir;
  assign rd_data_ev = acc.rd_rbr;
  assign wr_scr_ev  = acc.wr_scr;
  assign lsr_rd_ev  = acc.rd_lsr;

  uart_rf_decode u_dec (
    .addr (reg_addr),
    .wr   (reg_wr),
    .rd   (reg_rd),
    .dlab (dlab),
    .acc  (acc)
  );

  uart_rf_core #(
    .DIV_RESET    (DIV_RESET),
    .SCRATCH_FILL (SCRATCH_FILL)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .wdata    (reg_wdata),
    .tx_hold  (tx_hold),
    .rx_valid (rx_valid),
    .rx_kind  (rx_kind_e'(rx_kind)),
    .rx_data  (rx_data),
    .data_q   (data_q),
    .dll_q    (dll_q),
    .dlm_q    (dlm_q),
    .ier_q    (ier_q),
    .iir_q    (iir_q),
    .lcr_q    (lcr_q),
    .mcr_q    (mcr_q),
    .lsr_q    (lsr_q),
    .scr_q    (scr_q),
    .rx_take  (rx_take)
  );

  uart_rf_rdmux u_rdmux (
    .addr   (reg_addr),
    .rd     (reg_rd),
    .wr     (reg_wr),
    .dlab   (dlab),
    .data_q (data_q),
    .dll_q  (dll_q),
    .dlm_q  (dlm_q),
    .ier_q  (ier_q),
    .iir_q  (iir_q),
    .lcr_q  (lcr_q),
    .mcr_q  (mcr_q),
    .lsr_q  (lsr_q),
    .scr_q  (scr_q),
    .rdata  (reg_rdata)
  );

  assign tx_valid = acc.wr_thr;
  assign tx_data  = reg_wdata;
  assign irq      = ~iir_q[IIR_IDLE_B];

endmodule

// File: rtl/uart_rf_chk.sv
module uart_rf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dlab,
  input logic       rd_iir_ev,
  input logic       rd_data_ev,
  input logic       wr_scr_ev,
  input logic       lsr_rd_ev,
  input logic       rx_valid,
  input logic       tx_valid,
  input logic [7:0] iir_q,
  input logic [7:0] lsr_q,
  input logic [7:0] data_q,
  input logic [7:0] scr_q,
  input logic [7:0] reg_rdata
);

  assert_tx_dlab_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !dlab);

  assert_rx_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_ev && lsr_q[0] && !rx_valid) |=> (!lsr_q[0] && data_q == 8'h00));

  assert_iir_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iir_q != 8'h00);

  assert_iir_txclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_iir_ev |=> !iir_q[1]);

  assert_lsr_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd_ev |-> (reg_rdata[6:5] == 2'b11));

  assert_scr_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_scr_ev |=> (scr_q == 8'hFF));

  assert_rx_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !lsr_q[0]) |=> lsr_q[0]);

  assert_rx_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && lsr_q[0] && !rd_data_ev) |=> $stable(data_q));

endmodule

bind uart_regs uart_rf_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dlab       (dlab),
  .rd_iir_ev  (rd_iir_ev),
  .rd_data_ev (rd_data_ev),
  .wr_scr_ev  (wr_scr_ev),
  .lsr_rd_ev  (lsr_rd_ev),
  .rx_valid   (rx_valid),
  .tx_valid   (tx_valid),
  .iir_q      (u_core.iir_q),
  .lsr_q      (u_core.lsr_q),
  .data_q     (u_core.data_q),
  .scr_q      (u_core.scr_q),
  .reg_rdata  (reg_rdata)
);

// File: tb/uart_regs_tb.sv
module uart_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_hold = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0;
  logic [1:0] rx_kind = '0;
  logic [7:0] rx_data = '0;
  logic       irq;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  logic       cap_txv;
  logic [7:0] cap_txd;
  logic [7:0] rv;

  uart_regs u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tx_hold   (tx_hold),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_valid  (rx_valid),
    .rx_kind   (rx_kind),
    .rx_data   (rx_data),
    .irq       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      misses++;
      $display("FAIL watchdog expired act %0d exp <%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act %02h exp %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    #1;
    cap_txv = tx_valid;
    cap_txd = tx_data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_kind = k; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] got;
    bus_rd(a, got);
    chk(req, got, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    @(negedge clk);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    expect_rd("R1 data", 3'd0, 8'h00);
    expect_rd("R1 ier", 3'd1, 8'h00);
    expect_rd("R1 iir", 3'd2, 8'h01);
    expect_rd("R1 lcr", 3'd3, 8'h00);
    expect_rd("R1 mcr", 3'd4, 8'h00);
    expect_rd("R1 lsr", 3'd5, 8'h60);
    expect_rd("R8 msr", 3'd6, 8'hB0);
    expect_rd("R1 scr", 3'd7, 8'h00);
    bus_wr(3'd3, 8'h80);
    expect_rd("R1 dll", 3'd0, 8'h01);
    expect_rd("R1 dlm", 3'd1, 8'h00);

    // R2 divisor sweep under latch access
    for (int v = 0; v < 256; v++) begin
      bus_wr(3'd0, 8'(v));
      chk("R2 no tx dll", {7'd0, cap_txv}, 8'h00);
      bus_wr(3'd1, ~8'(v));
      expect_rd("R2 dll", 3'd0, 8'(v));
      expect_rd("R2 dlm", 3'd1, ~8'(v));
    end
    bus_wr(3'd3, 8'h00);
    expect_rd("R2 data untouched", 3'd0, 8'h00);
    expect_rd("R2 ier untouched", 3'd1, 8'h00);
    expect_rd("R2 iir untouched", 3'd2, 8'h01);

    // R14 line and modem control readback
    for (int v = 0; v < 128; v++) begin
      bus_wr(3'd3, 8'(v));
      expect_rd("R14 lcr", 3'd3, 8'(v));
    end
    bus_wr(3'd3, 8'h00);
    for (int v = 0; v < 256; v++) begin
      bus_wr(3'd4, 8'(v));
      expect_rd("R14 mcr", 3'd4, 8'(v));
    end

    // R9 scratch fill
    for (int v = 0; v < 256; v++) begin
      bus_wr(3'd7, 8'(v));
      expect_rd("R9 scr", 3'd7, 8'hFF);
    end

    // R7/R8/R6 ignored writes
    bus_wr(3'd5, 8'hFF);
    expect_rd("R7 lsr write ignored", 3'd5, 8'h60);
    bus_wr(3'd6, 8'h00);
    expect_rd("R8 msr write ignored", 3'd6, 8'hB0);
    bus_wr(3'd2, 8'hFF);
    expect_rd("R6 fcr write no effect", 3'd2, 8'h01);

    // R3 transmit with interrupts off
    for (int v = 0; v < 256; v++) begin
      bus_wr(3'd0, 8'(v));
      chk("R3 tx_valid", {7'd0, cap_txv}, 8'h01);
      chk("R3 tx_data", cap_txd, 8'(v));
    end
    chk("R13 irq quiet", {7'd0, irq}, 8'h00);
    expect_rd("R3 iir off", 3'd2, 8'h01);

    // R10 enable write marks tx ready without pending
    bus_wr(3'd1, 8'h02);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
    expect_rd("R10 iir", 3'd2, 8'h03);
    expect_rd("R6 iir after read", 3'd2, 8'h01);

    // R3 transmit raises interrupt
    bus_wr(3'd0, 8'h41);
    chk("R13 irq tx", {7'd0, irq}, 8'h01);
    expect_rd("R3 iir tx", 3'd2, 8'h02);
    chk("R6 irq cleared", {7'd0, irq}, 8'h00);
    expect_rd("R6 iir fallback", 3'd2, 8'h01);

    // R3 pacing hold
    tx_hold = 1'b1;
    bus_wr(3'd0, 8'h42);
    chk("R3 hold tx_valid", {7'd0, cap_txv}, 8'h01);
    chk("R3 hold irq", {7'd0, irq}, 8'h00);
    expect_rd("R3 hold iir", 3'd2, 8'h01);
    tx_hold = 1'b0;

    // R11/R4/R5 receive sweep, receive interrupt only
    bus_wr(3'd1, 8'h01);
    for (int v = 0; v < 256; v++) begin
      rx_push(2'd0, 8'(v));
      chk("R11 irq rx", {7'd0, irq}, 8'h01);
      expect_rd("R11 lsr", 3'd5, 8'h61);
      expect_rd("R6 iir rx kept", 3'd2, 8'h04);
      expect_rd("R4 data", 3'd0, 8'(v));
      expect_rd("R4 lsr drained", 3'd5, 8'h60);
      expect_rd("R5 iir", 3'd2, 8'h01);
    end

    // R11 drop while full, R4 stale read
    rx_push(2'd0, 8'h11);
    rx_push(2'd3, 8'h22);
    expect_rd("R11 dropped", 3'd0, 8'h11);
    expect_rd("R4 stale", 3'd0, 8'h00);
    expect_rd("R4 lsr unchanged", 3'd5, 8'h60);

    // R11 interrupts disabled
    bus_wr(3'd1, 8'h00);
    rx_push(2'd0, 8'h5C);
    chk("R11 no irq", {7'd0, irq}, 8'h00);
    expect_rd("R11 iir quiet", 3'd2, 8'h01);
    expect_rd("R11 data", 3'd0, 8'h5C);

    // R5/R6 both causes
    bus_wr(3'd1, 8'h03);
    expect_rd("R10 iir both en", 3'd2, 8'h03);
    bus_wr(3'd0, 8'h99);
    rx_push(2'd0, 8'h7E);
    expect_rd("R6 iir both", 3'd2, 8'h06);
    chk("R13 irq rx left", {7'd0, irq}, 8'h01);
    expect_rd("R6 iir rx left", 3'd2, 8'h04);
    expect_rd("R5 data", 3'd0, 8'h7E);
    expect_rd("R5 iir quiet", 3'd2, 8'h01);
    chk("R13 irq off", {7'd0, irq}, 8'h00);

    // R12 break events
    bus_wr(3'd1, 8'h01);
    rx_push(2'd1, 8'h5A);
    expect_rd("R12 lsr brk", 3'd5, 8'h71);
    expect_rd("R12 data zero", 3'd0, 8'h00);
    expect_rd("R12 brk held", 3'd5, 8'h70);
    rx_push(2'd2, 8'h33);
    expect_rd("R12 lsr brk off", 3'd5, 8'h61);
    expect_rd("R12 data zero off", 3'd0, 8'h00);
    expect_rd("R12 lsr idle", 3'd5, 8'h60);

    // R2 latch access hides data without draining it
    rx_push(2'd0, 8'h77);
    bus_wr(3'd3, 8'h80);
    expect_rd("R2 dll view", 3'd0, 8'hFF);
    expect_rd("R2 dlm view", 3'd1, 8'h00);
    bus_wr(3'd3, 8'h00);
    expect_rd("R2 lsr kept", 3'd5, 8'h61);
    expect_rd("R2 data kept", 3'd0, 8'h77);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule